// File: doc/BRIEF.md
# Monochrome 80x25 Text Display Generator

The block turns a text screen of 80 columns by 25 rows into a 640x400 monochrome video signal. A 25 MHz pixel clock gives 800 clocks per line and 449 lines per frame, which is about 70 frames per second. The block reads each character code from an external text memory. It then reads the matching glyph byte from an external font memory. That memory holds 16 planes of 256 bytes, one plane per glyph row. The result is a serial pixel stream, an active-low horizontal sync and an active-high vertical sync.

Each scanline is assembled one line ahead. While one of two line buffers is shifted out, the next line's 80 glyph bytes are fetched into the other buffer. The two buffers swap roles at every line boundary.

Both memories have a synchronous read port with one clock of latency: data appears in the clock after its address.

A frame-phase state machine tracks the position in the frame. The line counter runs from 0 to 448 and then wraps. The phases and their transitions are:

| Phase | Lines | Next phase | Entered at the end of the line before |
|---|---|---|---|
| PH_TOP | 0 to 1 | PH_VSYNC | line 2 |
| PH_VSYNC | 2 to 3 | PH_BACK | line 4 |
| PH_BACK | 4 to 37 | PH_RENDER | line 38 |
| PH_RENDER | 38 to 437 | PH_TAIL | line 438 |
| PH_TAIL | 438 to 440 | PH_CLEAR | line 441 |
| PH_CLEAR | 441 to 442 | PH_BLANK | line 443 |
| PH_BLANK | 443 to 448 | PH_TOP | line 0, on wrap |

Vertical sync follows PH_VSYNC. During PH_RENDER the block fetches glyphs. During PH_CLEAR it writes zeros into the buffer being prepared, so the buffers are dark before the next frame begins.

Timing convention used below: let t count rising clock edges since reset was released. The outputs seen after edge t describe column (t-1) mod 800 of line (t-1) div 800.

Top module: `textmode_vga`

## Requirements
- R1: While reset is high, and after it, until the first edge with reset low, pix is 0, hsync_n is 1, vsync is 0, txt_addr is 0 and font_addr is 0.
- R2: Every line lasts 800 clocks. hsync_n is 0 for columns 49 to 144 inclusive and 1 for every other column.
- R3: vsync is 1 for every column of lines 2 and 3 and 0 on lines 0, 1 and 4 onwards.
- R4: On a line L from 38 to 437, column c from 0 to 79 reads the text memory. After edge L*800+c+1, txt_addr equals ((L-38) div 16)*80 + c.
- R5: After edge L*800+c+3, font_addr equals ((L-38) mod 16)*256 + the code returned for column c. The glyph row is held in bits 11 to 8 and the code in bits 7 to 0.
- R6: On line L+1, for L from 38 to 437, the pixel of column x (0 to 639) is bit 7-(x mod 8) of the font byte fetched for character column x div 8 on line L. Bytes are sent most significant bit first, and 1 is lit.
- R7: pix is 0 on columns 640 to 799 of every line and on every column of lines outside 39 to 438.
- R8: Two successive visible lines each show their own glyph row. The line shown is the one built on the previous line, even though the next line is written into the other buffer while it is shown.
- R9: Reset raised in mid-frame returns the outputs to their R1 values. After release the frame restarts at line 0, column 0 with the R2, R3 and R6 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, 25 MHz nominal |
| rst | input | 1 | Synchronous reset, active high |
| txt_addr | output | 11 | Text memory address, row*80 + column |
| txt_data | input | 8 | Character code, valid one clock after its address |
| font_addr | output | 12 | Font memory address, glyph_row*256 + code |
| font_data | input | 8 | Glyph byte, valid one clock after its address |
| pix | output | 1 | Serial pixel, 1 = lit |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync | output | 1 | Vertical sync, active high |

## Verification
On every render line, two operations share clocks 4 to 84. Glyph bytes for the next line are written into one buffer while the current line's pixels are read out of the other. The bench provokes the overlap with a font whose bytes depend on the glyph row, so each scanline differs from its neighbours. It then judges the pixels of two adjacent lines, around a change of text row, against values computed from the font and text formulas. A wrong buffer choice, or a write landing in the buffer being shown, would display the neighbouring line's row and fail those comparisons.

// File: rtl/tmv_pkg.sv
package tmv_pkg;
    localparam int H_TOTAL   = 800;
    localparam int H_ACTIVE  = 640;
    localparam int HS_FIRST  = 49;
    localparam int HS_LAST   = 144;
    localparam int V_TOTAL   = 449;
    localparam int VS_FIRST  = 2;
    localparam int VS_LAST   = 3;
    localparam int RND_FIRST = 38;
    localparam int TXT_COLS  = 80;
    localparam int TXT_ROWS  = 25;
    localparam int GLYPH_H   = 16;
    localparam int GLYPH_W   = 8;
    localparam int CLR_FIRST = 441;
    localparam int CLR_LAST  = 442;

    typedef enum logic [2:0] {
        PH_TOP,
        PH_VSYNC,
        PH_BACK,
        PH_RENDER,
        PH_TAIL,
        PH_CLEAR,
        PH_BLANK
    } phase_t;
endpackage

// File: rtl/tmv_timing.sv
module tmv_timing
    import tmv_pkg::*;
#(
    parameter int HT   = H_TOTAL,
    parameter int HSA  = HS_FIRST,
    parameter int HSB  = HS_LAST,
    parameter int VT   = V_TOTAL,
    parameter int VSA  = VS_FIRST,
    parameter int VSB  = VS_LAST,
    parameter int R0   = RND_FIRST,
    parameter int RLEN = TXT_ROWS * GLYPH_H,
    parameter int C0   = CLR_FIRST,
    parameter int C1   = CLR_LAST,
    parameter int HW   = $clog2(HT),
    parameter int VW   = $clog2(VT)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [HW-1:0] hcnt,
    output logic [VW-1:0] vcnt,
    output logic          line_end,
    output logic          render,
    output logic          clr,
    output logic          vis_line,
    output logic          hsync_n,
    output logic          vsync
);
    localparam logic [HW-1:0] H_END  = HW'(HT - 1);
    localparam logic [HW-1:0] HS_A   = HW'(HSA);
    localparam logic [HW-1:0] HS_B   = HW'(HSB);
    localparam logic [HW-1:0] HS_FA  = HW'(HSA + 1);
    localparam logic [HW-1:0] HS_RA  = HW'(HSB + 2);
    localparam logic [VW-1:0] V_END  = VW'(VT - 1);
    localparam logic [VW-1:0] L_VS0  = VW'(VSA);
    localparam logic [VW-1:0] L_VS1  = VW'(VSB + 1);
    localparam logic [VW-1:0] L_R0   = VW'(R0);
    localparam logic [VW-1:0] L_R1   = VW'(R0 + RLEN);
    localparam logic [VW-1:0] L_C0   = VW'(C0);
    localparam logic [VW-1:0] L_C1   = VW'(C1 + 1);

    phase_t phase, phase_nx;
    logic [VW-1:0] vnext;

    assign line_end = (hcnt == H_END);
    assign vnext    = (vcnt == V_END) ? '0 : vcnt + 1'b1;

    // pixel and line counters
    always_ff @(posedge clk) begin
        if (rst) begin
            hcnt <= '0;
            vcnt <= '0;
        end else if (line_end) begin
            hcnt <= '0;
            vcnt <= vnext;
        end else begin
            hcnt <= hcnt + 1'b1;
        end
    end

    // phase register
    always_ff @(posedge clk) begin
        if (rst) phase <= PH_TOP;
        else     phase <= phase_nx;
    end

    // phase transitions, taken at the last clock of a line
    always_comb begin
        phase_nx = phase;
        if (line_end) begin
            unique case (phase)
                PH_TOP:    if (vnext == L_VS0) phase_nx = PH_VSYNC;
                PH_VSYNC:  if (vnext == L_VS1) phase_nx = PH_BACK;
                PH_BACK:   if (vnext == L_R0)  phase_nx = PH_RENDER;
                PH_RENDER: if (vnext == L_R1)  phase_nx = PH_TAIL;
                PH_TAIL:   if (vnext == L_C0)  phase_nx = PH_CLEAR;
                PH_CLEAR:  if (vnext == L_C1)  phase_nx = PH_BLANK;
                PH_BLANK:  if (vnext == '0)    phase_nx = PH_TOP;
                default:                       phase_nx = PH_TOP;
            endcase
        end
    end

    // phase-derived outputs
    assign render   = (phase == PH_RENDER);
    assign clr      = (phase == PH_CLEAR);
    assign vis_line = (vcnt > L_R0) && (vcnt <= L_R1);

    always_ff @(posedge clk) begin
        if (rst) begin
            hsync_n <= 1'b1;
            vsync   <= 1'b0;
        end else begin
            hsync_n <= !((hcnt >= HS_A) && (hcnt <= HS_B));
            vsync   <= (phase == PH_VSYNC);
        end
    end

    assert_line_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        line_end |=> (hcnt == '0));
    assert_hsync_start_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(hsync_n) |-> (hcnt == HS_FA));
    assert_hsync_end_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(hsync_n) |-> (hcnt == HS_RA));
    assert_vsync_start_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(vsync) |-> (vcnt == L_VS0 && hcnt == HW'(1)));
    assert_vsync_end_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(vsync) |-> (vcnt == L_VS1 && hcnt == HW'(1)));
    assert_frame_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (line_end && vcnt == V_END) |=> (vcnt == '0 && phase == PH_TOP));
endmodule

// File: rtl/tmv_fetch.sv
module tmv_fetch #(
    parameter int HW        = 10,
    parameter int VW        = 9,
    parameter int TXT_COLS  = 80,
    parameter int TXT_ROWS  = 25,
    parameter int GLYPH_H   = 16,
    parameter int RND_FIRST = 38,
    parameter int DW        = 8,
    parameter int TAW       = $clog2(TXT_COLS * TXT_ROWS),
    parameter int GW        = $clog2(GLYPH_H),
    parameter int FAW       = GW + DW,
    parameter int CW        = $clog2(TXT_COLS)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [HW-1:0]  hcnt,
    input  logic [VW-1:0]  vcnt,
    input  logic           render,
    input  logic [DW-1:0]  txt_data,
    output logic [TAW-1:0] txt_addr,
    output logic [FAW-1:0] font_addr,
    output logic           wr_en,
    output logic [CW-1:0]  wr_col
);
    localparam int STAGES = 4;
    localparam logic [TAW-1:0] CELLS = TAW'(TXT_COLS * TXT_ROWS);

    logic [VW-1:0]  vrel;
    logic [GW-1:0]  grow;
    logic [TAW-1:0] base;
    logic           fetch_go;
    logic [STAGES-1:0] vld;
    logic [CW-1:0]  col [STAGES];

    assign vrel     = vcnt - VW'(RND_FIRST);
    assign grow     = vrel[GW-1:0];
    assign base     = TAW'(vrel >> GW) * TAW'(TXT_COLS);
    assign fetch_go = render && (hcnt < HW'(TXT_COLS));

    // column tags travel alongside the two memory latencies
    always_ff @(posedge clk) begin
        if (rst) begin
            vld <= '0;
            for (int i = 0; i < STAGES; i++) col[i] <= '0;
        end else begin
            vld <= {vld[STAGES-2:0], fetch_go};
            col[0] <= CW'(hcnt);
            for (int i = 1; i < STAGES; i++) col[i] <= col[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            txt_addr  <= '0;
            font_addr <= '0;
        end else begin
            if (fetch_go) txt_addr  <= base + TAW'(hcnt);
            if (vld[1])   font_addr <= {grow, txt_data};
        end
    end

    assign wr_en  = vld[STAGES-1];
    assign wr_col = col[STAGES-1];

    assert_write_in_render_R4: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> render);
    assert_text_range_R4: assert property (@(posedge clk) disable iff (rst)
        vld[0] |-> (txt_addr < CELLS));
endmodule

// File: rtl/tmv_linebuf.sv
module tmv_linebuf #(
    parameter int HW       = 10,
    parameter int TXT_COLS = 80,
    parameter int H_ACTIVE = 640,
    parameter int DW       = 8,
    parameter int CW       = $clog2(TXT_COLS),
    parameter int BW       = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [HW-1:0] hcnt,
    input  logic          line_end,
    input  logic          vis_line,
    input  logic          clr,
    input  logic          wr_en,
    input  logic [CW-1:0] wr_col,
    input  logic [DW-1:0] wr_data,
    output logic          pix
);
    localparam logic [HW-1:0] H_ACT = HW'(H_ACTIVE);

    logic                 sel;
    logic                 in_act;
    logic [CW-1:0]        rd_idx;
    logic [BW-1:0]        bpos;
    logic [1:0][DW-1:0]   rd_byte;
    logic [DW-1:0]        cur_byte;

    assign in_act   = (hcnt < H_ACT);
    assign rd_idx   = in_act ? CW'(hcnt >> BW) : '0;
    assign bpos     = BW'(DW - 1) - hcnt[BW-1:0];
    assign cur_byte = rd_byte[sel];

    // front buffer select swaps at every line boundary
    always_ff @(posedge clk) begin
        if (rst)           sel <= 1'b0;
        else if (line_end) sel <= ~sel;
    end

    for (genvar b = 0; b < 2; b++) begin : g_buf
        logic [DW-1:0] mem [TXT_COLS];
        logic          is_back;
        assign is_back    = (sel != 1'(b));
        assign rd_byte[b] = mem[rd_idx];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < TXT_COLS; i++) mem[i] <= '0;
            end else if (is_back) begin
                if (clr && hcnt == '0) begin
                    for (int i = 0; i < TXT_COLS; i++) mem[i] <= '0;
                end else if (wr_en) begin
                    mem[wr_col] <= wr_data;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pix <= 1'b0;
        else     pix <= (in_act && vis_line) ? cur_byte[bpos] : 1'b0;
    end

    assert_dark_outside_R7: assert property (@(posedge clk) disable iff (rst)
        pix |-> ($past(hcnt) < H_ACT && $past(vis_line)));
    assert_write_before_swap_R8: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !line_end);
    assert_clear_idle_R8: assert property (@(posedge clk) disable iff (rst)
        clr |-> !wr_en);
endmodule

// File: rtl/textmode_vga.sv
module textmode_vga
    import tmv_pkg::*;
#(
    parameter int COLS = TXT_COLS,
    parameter int ROWS = TXT_ROWS,
    parameter int GH   = GLYPH_H,
    parameter int DW   = GLYPH_W,
    parameter int TAW  = $clog2(COLS * ROWS),
    parameter int FAW  = $clog2(GH) + DW
) (
    input  logic           clk,
    input  logic           rst,
    output logic [TAW-1:0] txt_addr,
    input  logic [DW-1:0]  txt_data,
    output logic [FAW-1:0] font_addr,
    input  logic [DW-1:0]  font_data,
    output logic           pix,
    output logic           hsync_n,
    output logic           vsync
);
    localparam int HW = $clog2(H_TOTAL);
    localparam int VW = $clog2(V_TOTAL);
    localparam int CW = $clog2(COLS);

    logic [HW-1:0] hcnt;
    logic [VW-1:0] vcnt;
    logic          line_end, render, clr, vis_line;
    logic          wr_en;
    logic [CW-1:0] wr_col;

    tmv_timing #(
        .RLEN(ROWS * GH), .HW(HW), .VW(VW)
    ) u_timing (
        .clk(clk), .rst(rst), .hcnt(hcnt), .vcnt(vcnt), .line_end(line_end),
        .render(render), .clr(clr), .vis_line(vis_line),
        .hsync_n(hsync_n), .vsync(vsync)
    );

    tmv_fetch #(
        .HW(HW), .VW(VW), .TXT_COLS(COLS), .TXT_ROWS(ROWS), .GLYPH_H(GH),
        .RND_FIRST(RND_FIRST), .DW(DW), .TAW(TAW), .FAW(FAW), .CW(CW)
    ) u_fetch (
        .clk(clk), .rst(rst), .hcnt(hcnt), .vcnt(vcnt), .render(render),
        .txt_data(txt_data), .txt_addr(txt_addr), .font_addr(font_addr),
        .wr_en(wr_en), .wr_col(wr_col)
    );

    tmv_linebuf #(
        .HW(HW), .TXT_COLS(COLS), .H_ACTIVE(COLS * DW), .DW(DW), .CW(CW)
    ) u_linebuf (
        .clk(clk), .rst(rst), .hcnt(hcnt), .line_end(line_end),
        .vis_line(vis_line), .clr(clr), .wr_en(wr_en), .wr_col(wr_col),
        .wr_data(font_data), .pix(pix)
    );
endmodule

// File: tb/sim_textmode_vga.sv
`timescale 1ns/1ps
module sim_textmode_vga;
    localparam int CLK_PERIOD = 40;
    localparam int HT = 800;
    localparam int NP = 28;
    localparam int WATCHDOG = 190000;

    // probe table: line, column, kind
    // kind 0: pix/hsync/vsync, 1: txt_addr, 2: font_addr, 3: pix for R8
    localparam int PL [NP] = '{0,0,0,0,0,1,2,3,4, 38,38,38,38,38, 39,39,39,39,39,
                               40, 54,55,55, 70,100,101,130,149};
    localparam int PC [NP] = '{0,48,49,144,145,700,0,799,0, 0,0,10,79,79, 0,5,639,640,799,
                               17, 300,300,301, 33,123,40,600,7};
    localparam int PK [NP] = '{0,0,0,0,0,0,0,0,0, 1,2,0,1,2, 0,0,0,0,0,
                               0, 3,3,3, 1,0,2,0,0};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [10:0] txt_addr;
    logic [7:0]  txt_data = '0;
    logic [11:0] font_addr;
    logic [7:0]  font_data = '0;
    logic        pix, hsync_n, vsync;

    int nchk = 0;
    int nerr = 0;
    int ecount = 0;
    bit done = 0;

    function automatic int tcode(int a);
        return (a * 37 + 11) % 256;
    endfunction

    function automatic int fbyte(int a);
        return ((a * 73) ^ (a >> 5)) & 255;
    endfunction

    function automatic int exp_pix(int l, int c);
        int v, a, b;
        if (c >= 640 || l < 39 || l > 438) return 0;
        v = l - 39;
        a = (v / 16) * 80 + c / 8;
        b = fbyte((v % 16) * 256 + tcode(a));
        return (b >> (7 - c % 8)) & 1;
    endfunction

    function automatic int exp_hs(int c);
        return (c >= 49 && c <= 144) ? 0 : 1;
    endfunction

    function automatic int exp_vs(int l);
        return (l == 2 || l == 3) ? 1 : 0;
    endfunction

    textmode_vga u0 (
        .clk(clk), .rst(rst), .txt_addr(txt_addr), .txt_data(txt_data),
        .font_addr(font_addr), .font_data(font_data),
        .pix(pix), .hsync_n(hsync_n), .vsync(vsync)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // memory models with one clock of read latency
    always @(posedge clk) begin
        txt_data  <= 8'(tcode(int'(txt_addr)));
        font_data <= 8'(fbyte(int'(font_addr)));
    end

    always @(posedge clk) begin
        if (rst) ecount <= 0;
        else     ecount <= ecount + 1;
    end

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_edge(input int n);
        while (ecount < n) @(negedge clk);
    endtask

    task automatic check_rst_outputs(input string tag);
        chk(tag, int'(pix), 0);
        chk(tag, int'(hsync_n), 1);
        chk(tag, int'(vsync), 0);
        chk(tag, int'(txt_addr), 0);
        chk(tag, int'(font_addr), 0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1;
            nchk++;
            nerr++;
            $display("FAIL watchdog actual %0d expected 0", ecount);
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    initial begin
        int tgt, l, c, a;
        repeat (3) @(negedge clk);
        check_rst_outputs("R1");
        rst = 1'b0;
        @(negedge clk);
        // one edge after release: column 0 of line 0 is described
        chk("R1", int'(hsync_n), 1);

        for (int i = 0; i < NP; i++) begin
            l = PL[i];
            c = PC[i];
            tgt = l * HT + c + 1 + ((PK[i] == 2) ? 2 : 0);
            wait_edge(tgt);
            case (PK[i])
                0: begin
                    if (c < 640 && l >= 39 && l <= 438)
                        chk("R6", int'(pix), exp_pix(l, c));
                    else
                        chk("R7", int'(pix), exp_pix(l, c));
                    chk("R2", int'(hsync_n), exp_hs(c));
                    chk("R3", int'(vsync), exp_vs(l));
                end
                1: chk("R4", int'(txt_addr), ((l - 38) / 16) * 80 + c);
                2: begin
                    a = ((l - 38) / 16) * 80 + c;
                    chk("R5", int'(font_addr), ((l - 38) % 16) * 256 + tcode(a));
                end
                default: chk("R8", int'(pix), exp_pix(l, c));
            endcase
        end

        // reset raised in mid-frame
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check_rst_outputs("R9");
        rst = 1'b0;
        wait_edge(1 * HT + 799 + 1);
        chk("R9", int'(vsync), 0);
        wait_edge(2 * HT + 0 + 1);
        chk("R9", int'(vsync), 1);
        wait_edge(2 * HT + 50 + 1);
        chk("R9", int'(hsync_n), 0);
        wait_edge(39 * HT + 3 + 1);
        chk("R9", int'(pix), exp_pix(39, 3));
        wait_edge(39 * HT + 200 + 1);
        chk("R9", int'(pix), exp_pix(39, 200));

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end
endmodule